// File: doc/BRIEF.md
# Serial DAC Input Register Interface

This block is the digital front end of a serial-input voltage DAC. A host frames a transfer by pulling an active-low select line low, then presents data bits most significant first, one per rising edge of a serial clock. The block samples the serial clock, select, data, load and clear lines into a fast system clock domain through two-flop synchronisers. It then detects edges and shifts bits into a 16-bit shift register.

When select rises, the shift register word moves into an input register. A second register, the DAC register, holds the code that drives the converter. It copies the input register whenever the active-low load input is low. A host that ties load low therefore sees the code change right after each frame. A host that holds load high can write the word first and release it later with a load pulse.

A falling edge on the active-low clear input resets both registers to a clear code. Load pulses have no effect while clear stays low. The clear code, zero-scale or midscale, is chosen when the block is built. The system reset sets both registers to the clear code and leaves the shift register uninitialised. A narrower converter variant takes the upper bits of the 16-bit word.

Top module: `dac_serial_front`

## Requirements
- R1: After reset, dac_code_o equals the clear code: 0 when CLR_MID=0, and 1<<(DAC_W-1) when CLR_MID=1.
- R2: With ldac_ni low, a frame of 16 bits sent MSB first appears on dac_code_o after csn_i rises. The first bit sent is bit 15 of the word.
- R3: Serial clock edges while csn_i is high shift nothing. A following frame with no clock edges therefore reloads the previous word unchanged.
- R4: When a frame has more than 16 rising clock edges, only the last 16 bits are kept.
- R5: When a frame has fewer than 16 bits (n bits), the word is the previous shift contents moved up by n, with the new bits in the low n positions.
- R6: While ldac_ni is high, dac_code_o does not change on a frame end. A later low level on ldac_ni copies the input register to dac_code_o.
- R7: A falling edge on clr_ni sets both the input register and the DAC register to the clear code. A load pulse after clear is released then still gives the clear code.
- R8: While clr_ni is held low, load pulses leave dac_code_o unchanged. A frame ended during that time still loads the input register.
- R9: With DAC_W below 16, dac_code_o is bits 15 down to 16-DAC_W of the received word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on) |
| sclk_i | input | 1 | Serial clock; data sampled on its rising edge |
| csn_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data, MSB first |
| ldac_ni | input | 1 | Active-low DAC register load level |
| clr_ni | input | 1 | Active-low clear, falling-edge triggered |
| dac_code_o | output | DAC_W | DAC register contents driving the converter |

## Verification
The bench builds two instances on shared serial lines. The first is a full 16-bit instance with CLR_MID=1, so reset and clear must give midscale. The second is a 12-bit instance with CLR_MID=0, which clears to zero and must show the upper 12 bits of each word. Because both instances see every frame, a single stimulus checks both clear-code choices and the bit-selection path for the narrow variant. The stimulus covers long frames, short frames, clocking while deselected, deferred load and a held clear. Together these reach the stale-bit and masking behaviour.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int unsigned WORD_W = 16;

  function automatic logic [WORD_W-1:0] clear_word(input bit mid);
    clear_word = mid ? {1'b1, {(WORD_W-1){1'b0}}} : '0;
  endfunction
endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dac_fe_shifter.sv
module dac_fe_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              load_stb_o
);
  logic sclk_prev_q, csn_prev_q;
  logic [WORD_W-1:0] shift_q;
  logic sclk_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      csn_prev_q  <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_i;
      csn_prev_q  <= csn_i;
    end
  end

  assign sclk_rise  = sclk_i && !sclk_prev_q;
  assign load_stb_o = csn_i && !csn_prev_q;

  // Power-on contents are undefined by design: no reset.
  always_ff @(posedge clk_i) begin
    if (sclk_rise && !csn_i) shift_q <= {shift_q[WORD_W-2:0], sdi_i};
  end

  assign word_o = shift_q;

  // R3: deselected clock edges shift nothing
  a_r3_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_i |=> $stable(shift_q));
  // R2: a sampled edge moves the new bit into position 0
  a_r2_bit_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && !csn_i) |=> shift_q[0] == $past(sdi_i));
endmodule

// File: rtl/dac_fe_regs.sv
module dac_fe_regs #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DAC_W  = 16,
  parameter bit          CLR_MID = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_stb_i,
  input  logic              ldac_ni,
  input  logic              clr_ni,
  output logic [DAC_W-1:0]  code_o
);
  localparam logic [WORD_W-1:0] CLR_WORD = dac_fe_pkg::clear_word(CLR_MID);
  localparam logic [DAC_W-1:0]  CLR_CODE = CLR_WORD[WORD_W-1 -: DAC_W];

  logic [DAC_W-1:0] in_q, dac_q;
  logic clr_prev_q, clr_fall;

  assign clr_fall = clr_prev_q && !clr_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_prev_q <= 1'b1;
      in_q       <= CLR_CODE;
      dac_q      <= CLR_CODE;
    end else begin
      clr_prev_q <= clr_ni;
      if (clr_fall) begin
        in_q  <= CLR_CODE;
        dac_q <= CLR_CODE;
      end else begin
        if (load_stb_i) in_q <= word_i[WORD_W-1 -: DAC_W];
        if (!ldac_ni && clr_ni) dac_q <= in_q;
      end
    end
  end

  assign code_o = dac_q;

  // R7: clear edge forces both registers
  a_r7_clear_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_fall |=> (in_q == CLR_CODE) && (dac_q == CLR_CODE));
  // R8: held clear freezes the DAC register
  a_r8_clr_masks_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && !clr_fall) |=> $stable(dac_q));
  // R6: load high freezes the DAC register
  a_r6_hold_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldac_ni && !clr_fall) |=> $stable(dac_q));
  // R2: frame end captures the word top bits
  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_stb_i && !clr_fall) |=> in_q == $past(word_i[WORD_W-1 -: DAC_W]));
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front #(
  parameter int unsigned DAC_W   = 16,
  parameter bit          CLR_MID = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             csn_i,
  input  logic             sdi_i,
  input  logic             ldac_ni,
  input  logic             clr_ni,
  output logic [DAC_W-1:0] dac_code_o
);
  localparam int unsigned WORD_W = dac_fe_pkg::WORD_W;

  logic [4:0] raw, syn;
  logic [WORD_W-1:0] word;
  logic load_stb;

  assign raw = {clr_ni, ldac_ni, sdi_i, csn_i, sclk_i};

  dac_fe_sync #(.W(5), .RST_VAL(5'b11010)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  dac_fe_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(syn[0]), .csn_i(syn[1]),
    .sdi_i(syn[2]), .word_o(word), .load_stb_o(load_stb)
  );

  dac_fe_regs #(.WORD_W(WORD_W), .DAC_W(DAC_W), .CLR_MID(CLR_MID)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_i(word), .load_stb_i(load_stb),
    .ldac_ni(syn[3]), .clr_ni(syn[4]), .code_o(dac_code_o)
  );

  // R9: width choice is legal
  initial a_r9_width_ok: assert (DAC_W >= 1 && DAC_W <= WORD_W);
endmodule

// File: tb/dac_serial_front_test.sv
module dac_serial_front_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0, ldac_n = 1'b0, clr_n = 1'b1;
  logic [15:0] code_w;
  logic [11:0] code_n;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_serial_front #(.DAC_W(16), .CLR_MID(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .ldac_ni(ldac_n), .clr_ni(clr_n), .dac_code_o(code_w));
  dac_serial_front #(.DAC_W(12), .CLR_MID(1'b0)) uut_narrow (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .ldac_ni(ldac_n), .clr_ni(clr_n), .dac_code_o(code_n));

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_both(input string req, input logic [15:0] word_w, input logic [11:0] word_n);
    chk(req, code_w, word_w);
    chk({req, " narrow R9"}, {4'h0, code_n}, {4'h0, word_n});
  endtask

  task automatic clock_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      ticks(6);
      sclk = 1'b1;
      ticks(6);
      sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] v, input int n);
    csn = 1'b0;
    ticks(6);
    clock_bits(v, n);
    ticks(6);
    csn = 1'b1;
    ticks(12);
  endtask

  task automatic pulse_load;
    ldac_n = 1'b0;
    ticks(8);
    ldac_n = 1'b1;
    ticks(8);
  endtask

  task automatic t_reset;
    chk_both("R1 reset clear code", 16'h8000, 12'h000);
  endtask

  task automatic t_basic;
    frame(32'hA5C3, 16);
    chk_both("R2 frame A5C3", 16'hA5C3, 12'hA5C);
    frame(32'h1234, 16);
    chk_both("R2 frame 1234", 16'h1234, 12'h123);
  endtask

  task automatic t_idle_clock;
    clock_bits(32'hFFFF, 16);
    ticks(12);
    chk_both("R3 clocks while deselected", 16'h1234, 12'h123);
    frame(32'h0, 0);
    chk_both("R3 empty frame reloads", 16'h1234, 12'h123);
  endtask

  task automatic t_long;
    frame(32'h9BEEF, 20);
    chk_both("R4 last 16 kept", 16'hBEEF, 12'hBEE);
  endtask

  task automatic t_short;
    frame(32'h3C, 8);
    chk_both("R5 short frame stale bits", 16'hEF3C, 12'hEF3);
  endtask

  task automatic t_deferred;
    ldac_n = 1'b1;
    ticks(8);
    frame(32'h0F0F, 16);
    chk_both("R6 held without load", 16'hEF3C, 12'hEF3);
    pulse_load();
    chk_both("R6 load pulse", 16'h0F0F, 12'h0F0);
  endtask

  task automatic t_clear;
    clr_n = 1'b0;
    ticks(10);
    chk_both("R7 clear edge", 16'h8000, 12'h000);
    clr_n = 1'b1;
    ticks(8);
    pulse_load();
    chk_both("R7 input reg cleared", 16'h8000, 12'h000);
  endtask

  task automatic t_clear_mask;
    frame(32'h7777, 16);
    clr_n = 1'b0;
    ticks(10);
    pulse_load();
    chk_both("R8 load masked by clear", 16'h8000, 12'h000);
    frame(32'h6A59, 16);
    pulse_load();
    chk_both("R8 masked after frame", 16'h8000, 12'h000);
    clr_n = 1'b1;
    ticks(8);
    chk_both("R8 release no load", 16'h8000, 12'h000);
    pulse_load();
    chk_both("R8 frame kept during clear", 16'h6A59, 12'h6A5);
    ldac_n = 1'b0;
    ticks(8);
  endtask

  task automatic t_narrow;
    frame(32'hFEDC, 16);
    chk("R9 wide FEDC", code_w, 16'hFEDC);
    chk("R9 narrow top bits", {4'h0, code_n}, 16'h0FED);
  endtask

  initial begin
    ticks(4);
    rst_n = 1'b1;
    ticks(8);
    t_reset();
    t_basic();
    t_idle_clock();
    t_long();
    t_short();
    t_deferred();
    t_clear();
    t_clear_mask();
    t_narrow();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule